// File: doc/BRIEF.md
# Dual-Role Serial Peripheral Controller

This block is a synchronous serial peripheral controller. It can act as the clock-generating master or as a slave clocked from outside. A frame is 8 or 16 bits long, chosen at run time, and is shifted either most-significant bit first or least-significant bit first. The transfer format is fixed: the clock idles low, data is sampled on the rising clock edge and changes on the falling edge. A small register port gives access to four words: control, status, data and match.

The select pin has three possible roles, set by two control bits. It can be an automatic select output that frames each master transfer. It can be an input that detects a competing master. It can be left entirely to other logic. Every completed received word is compared with the match register at the active width. An equal word raises a match flag, and that flag drives an interrupt line when the interrupt is enabled. In master mode, a change of frame width stops any transfer in progress.

Top module: `spi_ctl`

## Requirements
- R1: After reset the control word (address 0) reads 0 and the status word (address 1) reads 0x0002. In the status word, bit 0 is receive-full, bit 1 is transmit-empty, bit 2 is match and bit 3 is mode-fault. After reset sck_oe, mosi_oe, ss_oe and irq_match are all 0.
- R2: Control bit 3 sets the frame width: 0 gives 8 bits and 1 gives 16 bits. A master frame produces exactly that many rising edges on sck_o.
- R3: Control bit 2 sets the wire order. When it is 0, the first bit on the wire is bit 7 (8-bit) or bit 15 (16-bit) of the word. When it is 1, the first bit is bit 0.
- R4: The data register (address 2) keeps the same layout whatever the wire order. Bit 7 or bit 15 is the most significant bit, and in 8-bit mode bits 15..8 read 0. A completed frame sets receive-full, and reading the data register clears it.
- R5: In master mode (control bit 1, with bit 0 as the enable), a write to the data register starts a frame. sck_o idles low, and each half period lasts HALF_DIV clock cycles.
- R6: With the master role, mode-fault enable (bit 4) and select-output enable (bit 5) all set, ss_oe is 1. In this case ss_o goes low HALF_DIV cycles before the first rising edge of sck_o and returns high HALF_DIV cycles after the last falling edge.
- R7: ss_oe is 0 when bit 4 is clear or when the block is a slave. With bit 4 clear, a low level on ss_i has no effect on a master.
- R8: When the block is a master with bit 4 set and bit 5 clear, a low level on ss_i sets status bit 3 and clears control bit 1. sck_oe and mosi_oe then go to 0.
- R9: Status bit 2 is set when a completed received word equals the match register (address 3), compared over the active width only.
- R10: irq_match is 1 exactly when the match flag and control bit 6 are both set.
- R11: To clear the match flag or the mode-fault flag, the status register must be read while the flag is set, and then a 1 must be written to that bit. A status write that does not follow such a read leaves the flag unchanged.
- R12: In master mode, a control write that changes bit 3 stops the frame at once. ss_o goes high, no further sck_o edges follow, and the status returns to 0x0002.
- R13: In slave mode, while ss_i is low, the block samples mosi_i on the rising edges of sck_i and drives the transmit word on miso_o in the selected wire order. miso_oe is 1 during this time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data, 3 match |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (for read side effects) |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr |
| irq_match | output | 1 | Match interrupt request |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock in (slave) |
| mosi_o | output | 1 | Master data out |
| mosi_oe | output | 1 | Master data output enable |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Slave data output enable |
| miso_i | input | 1 | Master data in |
| ss_o | output | 1 | Automatic select output, low while framing |
| ss_oe | output | 1 | Select output enable |
| ss_i | input | 1 | Select input (slave select or fault sense) |

## Verification
A wrong bit counter or a wrong wire order shows up within a single frame. The count of sck_o edges is off, or the captured mosi_o sequence and the received data word disagree with the words the bench drives. A stuck master state machine or an abort that does not take effect keeps ss_o low or keeps sck_o toggling. This is visible at the pins within a few cycles of the control write. Flag errors appear in the very next status read: the match and mode-fault bits either stay set after the read-then-write sequence or clear without it.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_STAT  = 2'd1;
  localparam logic [1:0] ADDR_DATA  = 2'd2;
  localparam logic [1:0] ADDR_MATCH = 2'd3;

  localparam int CB_WIDE  = 3;
  localparam int SB_MATCH = 2;
  localparam int SB_FAULT = 3;

  typedef struct packed {
    logic mie;     // bit 6 match interrupt enable
    logic ssoe;    // bit 5 select output enable
    logic flten;   // bit 4 mode-fault function enable
    logic wide;    // bit 3 16-bit frames
    logic lsb;     // bit 2 least significant bit first
    logic master;  // bit 1 master role
    logic en;      // bit 0 block enable
  } ctrl_t;

  typedef enum logic [1:0] {MS_IDLE, MS_SETUP, MS_HOLD, MS_TAIL} mstate_t;
endpackage

// File: rtl/spi_ctl_regs.sv
module spi_ctl_regs
  import spi_ctl_pkg::*;
#(
  parameter int DW = 16,
  parameter int NW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          done,
  input  logic [DW-1:0] rx_word,
  input  logic          take,
  input  logic          fault_hit,
  output ctrl_t         ctrl,
  output logic [DW-1:0] tx_buf,
  output logic          tx_empty,
  output logic          abort,
  output logic          match_flag,
  output logic          fault_flag,
  output logic          irq
);
  localparam logic [DW-1:0] NMASK = {{(DW-NW){1'b0}}, {NW{1'b1}}};

  ctrl_t         ctrl_q, ctrl_d;
  logic [DW-1:0] tx_q, tx_d, rx_q, rx_d, mreg_q, mreg_d;
  logic          txe_q, txe_d, rxf_q, rxf_d, mf_q, mf_d, ff_q, ff_d;
  logic          arm_m_q, arm_m_d, arm_f_q, arm_f_d;
  logic [DW-1:0] wmask, rx_act;
  logic          wr_ctrl, wr_stat, wr_data, wr_match, rd_stat, rd_data;

  always_comb begin
    wmask    = ctrl_q.wide ? {DW{1'b1}} : NMASK;
    rx_act   = rx_word & wmask;
    wr_ctrl  = wr && (addr == ADDR_CTRL);
    wr_stat  = wr && (addr == ADDR_STAT);
    wr_data  = wr && (addr == ADDR_DATA);
    wr_match = wr && (addr == ADDR_MATCH);
    rd_stat  = rd && (addr == ADDR_STAT);
    rd_data  = rd && (addr == ADDR_DATA);
    abort    = wr_ctrl && ctrl_q.master && (wdata[CB_WIDE] != ctrl_q.wide);

    ctrl_d = ctrl_q; tx_d = tx_q; rx_d = rx_q; mreg_d = mreg_q;
    txe_d = txe_q; rxf_d = rxf_q; mf_d = mf_q; ff_d = ff_q;
    arm_m_d = arm_m_q; arm_f_d = arm_f_q;

    if (wr_ctrl)  ctrl_d = ctrl_t'(wdata[6:0]);
    if (take)     txe_d = 1'b1;
    if (wr_data) begin
      tx_d  = wdata;
      txe_d = 1'b0;
    end
    if (wr_match) mreg_d = wdata;
    if (rd_data)  rxf_d = 1'b0;
    if (done) begin
      rx_d  = rx_act;
      rxf_d = 1'b1;
      if (rx_act == (mreg_q & wmask)) mf_d = 1'b1;
    end
    if (rd_stat) begin
      arm_m_d = mf_q;
      arm_f_d = ff_q;
    end
    if (wr_stat) begin
      if (wdata[SB_MATCH] && arm_m_q) mf_d = 1'b0;
      if (wdata[SB_FAULT] && arm_f_q) ff_d = 1'b0;
      arm_m_d = 1'b0;
      arm_f_d = 1'b0;
    end
    if (fault_hit) begin
      ff_d          = 1'b1;
      ctrl_d.master = 1'b0;
    end
    if (abort) begin
      txe_d = 1'b1; rxf_d = 1'b0; mf_d = 1'b0; ff_d = 1'b0;
      arm_m_d = 1'b0; arm_f_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; tx_q <= '0; rx_q <= '0; mreg_q <= '0;
      txe_q <= 1'b1; rxf_q <= 1'b0; mf_q <= 1'b0; ff_q <= 1'b0;
      arm_m_q <= 1'b0; arm_f_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d; tx_q <= tx_d; rx_q <= rx_d; mreg_q <= mreg_d;
      txe_q <= txe_d; rxf_q <= rxf_d; mf_q <= mf_d; ff_q <= ff_d;
      arm_m_q <= arm_m_d; arm_f_q <= arm_f_d;
    end
  end

  always_comb begin
    case (addr)
      ADDR_CTRL: rdata = {{(DW-7){1'b0}}, ctrl_q};
      ADDR_STAT: rdata = {{(DW-4){1'b0}}, ff_q, mf_q, txe_q, rxf_q};
      ADDR_DATA: rdata = rx_q;
      default:   rdata = mreg_q;
    endcase
  end

  assign ctrl       = ctrl_q;
  assign tx_buf     = tx_q;
  assign tx_empty   = txe_q;
  assign match_flag = mf_q;
  assign fault_flag = ff_q;
  assign irq        = mf_q & ctrl_q.mie;
endmodule

// File: rtl/spi_ctl_ssdec.sv
module spi_ctl_ssdec (
  input  logic en,
  input  logic master,
  input  logic flt_en,
  input  logic out_en,
  input  logic busy,
  output logic ss_o,
  output logic ss_oe,
  output logic fault_watch
);
  always_comb begin
    ss_oe       = en & master & flt_en & out_en;
    fault_watch = en & master & flt_en & ~out_en;
    ss_o        = ~(busy & master);
  end
endmodule

// File: rtl/spi_ctl_shift.sv
module spi_ctl_shift
  import spi_ctl_pkg::*;
#(
  parameter int DW       = 16,
  parameter int NW       = 8,
  parameter int HALF_DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          master,
  input  logic          lsb,
  input  logic          wide,
  input  logic          abort,
  input  logic [DW-1:0] tx_buf,
  input  logic          tx_empty,
  input  logic          sck_i,
  input  logic          mosi_i,
  input  logic          miso_i,
  input  logic          ss_i,
  output logic          take,
  output logic          done,
  output logic [DW-1:0] rx_word,
  output logic          busy,
  output logic          sck_o,
  output logic          mosi_o,
  output logic          miso_o,
  output logic          selected
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BW = $clog2(DW);
  localparam logic [CW-1:0] DIV_END = CW'(HALF_DIV - 1);

  mstate_t       st_q, st_d;
  logic [CW-1:0] div_q, div_d;
  logic [BW-1:0] cnt_q, cnt_d, last, pos;
  logic [DW-1:0] txw_q, txw_d, rxw_q, rxw_d;
  logic          done_q, done_d;
  logic [2:0]    sck_s, ss_s;
  logic [1:0]    mosi_s;
  logic          half, run_m, s_rise, s_fall, ss_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= 3'b000; ss_s <= 3'b111; mosi_s <= 2'b00;
    end else begin
      sck_s  <= {sck_s[1:0], sck_i};
      ss_s   <= {ss_s[1:0], ss_i};
      mosi_s <= {mosi_s[0], mosi_i};
    end
  end

  always_comb begin
    selected = ~ss_s[1];
    s_rise   = sck_s[1] & ~sck_s[2];
    s_fall   = ~sck_s[1] & sck_s[2];
    ss_fall  = ss_s[2] & ~ss_s[1];
    last     = wide ? BW'(DW - 1) : BW'(NW - 1);
    pos      = lsb ? cnt_q : (last - cnt_q);
    half     = (div_q == DIV_END);
    run_m    = en & master;

    st_d = st_q; div_d = div_q; cnt_d = cnt_q;
    txw_d = txw_q; rxw_d = rxw_q; done_d = 1'b0; take = 1'b0;

    if (run_m) begin
      if (st_q != MS_IDLE) div_d = half ? '0 : div_q + 1'b1;
      case (st_q)
        MS_IDLE: if (!tx_empty) begin
          take = 1'b1; txw_d = tx_buf; cnt_d = '0; div_d = '0; st_d = MS_SETUP;
        end
        MS_SETUP: if (half) begin
          st_d = MS_HOLD;
          rxw_d[pos] = miso_i;
        end
        MS_HOLD: if (half) begin
          if (cnt_q == last) st_d = MS_TAIL;
          else begin
            cnt_d = cnt_q + 1'b1;
            st_d  = MS_SETUP;
          end
        end
        default: if (half) begin
          st_d   = MS_IDLE;
          done_d = 1'b1;
        end
      endcase
    end else begin
      st_d  = MS_IDLE;
      div_d = '0;
      if (en) begin
        if (!selected) cnt_d = '0;
        if (ss_fall) begin
          txw_d = tx_buf;
          take  = ~tx_empty;
          cnt_d = '0;
        end else if (selected && s_rise) begin
          rxw_d[pos] = mosi_s[1];
          done_d     = (cnt_q == last);
        end else if (selected && s_fall) begin
          cnt_d = (cnt_q == last) ? '0 : cnt_q + 1'b1;
        end
      end
    end

    if (abort) begin
      st_d = MS_IDLE; div_d = '0; cnt_d = '0; done_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= MS_IDLE; div_q <= '0; cnt_q <= '0;
      txw_q <= '0; rxw_q <= '0; done_q <= 1'b0;
    end else begin
      st_q <= st_d; div_q <= div_d; cnt_q <= cnt_d;
      txw_q <= txw_d; rxw_q <= rxw_d; done_q <= done_d;
    end
  end

  assign busy    = (st_q != MS_IDLE);
  assign sck_o   = (st_q == MS_HOLD);
  assign mosi_o  = busy ? txw_q[pos] : 1'b0;
  assign miso_o  = txw_q[pos];
  assign done    = done_q;
  assign rx_word = rxw_q;
endmodule

// File: rtl/spi_ctl.sv
module spi_ctl
  import spi_ctl_pkg::*;
#(
  parameter int DW       = 16,
  parameter int NW       = 8,
  parameter int HALF_DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_match,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          sck_i,
  output logic          mosi_o,
  output logic          mosi_oe,
  input  logic          mosi_i,
  output logic          miso_o,
  output logic          miso_oe,
  input  logic          miso_i,
  output logic          ss_o,
  output logic          ss_oe,
  input  logic          ss_i
);
  logic [1:0]    rs_q;
  logic          rst_ni;
  ctrl_t         ctrl;
  logic [DW-1:0] tx_buf, rx_word;
  logic          tx_empty, take, selected, fault_watch, fault_hit;
  logic          busy_w, done_w, abort_w, match_w, fault_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  spi_ctl_regs #(.DW(DW), .NW(NW)) u_regs (
    .clk(clk), .rst_n(rst_ni), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
    .wdata(reg_wdata), .rdata(reg_rdata), .done(done_w), .rx_word(rx_word),
    .take(take), .fault_hit(fault_hit), .ctrl(ctrl), .tx_buf(tx_buf),
    .tx_empty(tx_empty), .abort(abort_w), .match_flag(match_w),
    .fault_flag(fault_w), .irq(irq_match)
  );

  spi_ctl_shift #(.DW(DW), .NW(NW), .HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst_n(rst_ni), .en(ctrl.en), .master(ctrl.master),
    .lsb(ctrl.lsb), .wide(ctrl.wide), .abort(abort_w), .tx_buf(tx_buf),
    .tx_empty(tx_empty), .sck_i(sck_i), .mosi_i(mosi_i), .miso_i(miso_i),
    .ss_i(ss_i), .take(take), .done(done_w), .rx_word(rx_word),
    .busy(busy_w), .sck_o(sck_o), .mosi_o(mosi_o), .miso_o(miso_o),
    .selected(selected)
  );

  spi_ctl_ssdec u_ssdec (
    .en(ctrl.en), .master(ctrl.master), .flt_en(ctrl.flten),
    .out_en(ctrl.ssoe), .busy(busy_w), .ss_o(ss_o), .ss_oe(ss_oe),
    .fault_watch(fault_watch)
  );

  assign fault_hit = fault_watch & selected;
  assign sck_oe    = ctrl.en & ctrl.master;
  assign mosi_oe   = ctrl.en & ctrl.master;
  assign miso_oe   = ctrl.en & ~ctrl.master & selected;
endmodule

// File: rtl/spi_ctl_chk.sv
module spi_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic sck_o,
  input logic sck_oe,
  input logic ss_o,
  input logic ss_oe,
  input logic irq_match,
  input logic busy_w,
  input logic done_w,
  input logic abort_w,
  input logic match_w,
  input logic fault_w
);
  a_r12_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort_w |=> !busy_w);
  a_r5_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_w |-> !sck_o);
  a_r8_fault_stops_clock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_w) |-> !sck_oe);
  a_r9_match_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_w) |-> $past(done_w));
  a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_match |-> match_w);
  a_r6_select_covers_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_oe && sck_o) |-> !ss_o);
endmodule

bind spi_ctl spi_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck_o(sck_o), .sck_oe(sck_oe), .ss_o(ss_o),
  .ss_oe(ss_oe), .irq_match(irq_match), .busy_w(busy_w), .done_w(done_w),
  .abort_w(abort_w), .match_w(match_w), .fault_w(fault_w)
);

// File: tb/spi_ctl_bench.sv
`timescale 1ns/1ps
module spi_ctl_bench;
  localparam int HALF = 4;
  localparam real TCK = 5.0;

  logic        clk, rst_n;
  logic [1:0]  reg_addr;
  logic        reg_wr, reg_rd;
  logic [15:0] reg_wdata, reg_rdata;
  logic        irq_match, sck_o, sck_oe, sck_i, mosi_o, mosi_oe, mosi_i;
  logic        miso_o, miso_oe, miso_i, ss_o, ss_oe, ss_i;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int ncap   = 0;
  int kidx   = 0;
  logic        cap [32];
  logic [15:0] cur_pat;
  logic        cur_lsb;
  int          cur_w;
  realtime     t_ssfall, t_ssrise, t_first, t_lastfall;

  spi_ctl u_spi_ctl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_match(irq_match), .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i), .miso_o(miso_o),
    .miso_oe(miso_oe), .miso_i(miso_i), .ss_o(ss_o), .ss_oe(ss_oe), .ss_i(ss_i)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  always @(posedge sck_o) begin
    if (ncap == 0) t_first = $realtime;
    if (ncap < 32) cap[ncap] = mosi_o;
    ncap++;
  end
  always @(negedge sck_o) begin
    t_lastfall = $realtime;
    kidx++;
    if (kidx < cur_w) miso_i = cur_lsb ? cur_pat[kidx] : cur_pat[cur_w-1-kidx];
  end
  always @(negedge ss_o) t_ssfall = $realtime;
  always @(posedge ss_o) t_ssrise = $realtime;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic clr_flags();
    logic [15:0] v;
    rd(2'd1, v);
    wr(2'd1, 16'h000C);
    rd(2'd2, v);
  endtask

  // master frame with automatic select; sweeps width, order and data
  task automatic master_frame(input bit wide, input bit lsb, input logic [15:0] tx,
                              input logic [15:0] pat, input logic [15:0] mval);
    logic [15:0] v, mask, rebuilt;
    int w;
    w    = wide ? 16 : 8;
    mask = wide ? 16'hFFFF : 16'h00FF;
    wr(2'd0, 16'h0033 | (16'(lsb) << 2) | (16'(wide) << 3));
    wr(2'd3, mval);
    cur_pat = pat; cur_lsb = lsb; cur_w = w; kidx = 0; ncap = 0;
    miso_i  = lsb ? pat[0] : pat[w-1];
    wr(2'd2, tx);
    wait (ss_o == 1'b0);
    wait (ss_o == 1'b1);
    repeat (3) @(negedge clk);
    check("R2 sck edge count", 32'(ncap), 32'(w));
    rebuilt = '0;
    for (int k = 0; k < w; k++) rebuilt[lsb ? k : w-1-k] = cap[k];
    check("R3 wire order of mosi", 32'(rebuilt), 32'(tx & mask));
    check("R3 first bit on wire", 32'(cap[0]), 32'(lsb ? tx[0] : tx[w-1]));
    check("R6 select lead", 32'(int'((t_first - t_ssfall) / TCK)), 32'(HALF));
    check("R6 select trail", 32'(int'((t_ssrise - t_lastfall) / TCK)), 32'(HALF));
    rd(2'd2, v);
    check("R4 received word layout", 32'(v), 32'(pat & mask));
    rd(2'd1, v);
    check("R9 match flag", 32'(v[2]), 32'(((pat ^ mval) & mask) == 16'h0));
  endtask

  task automatic slave_frame(input bit wide, input bit lsb, input logic [15:0] txw,
                             input logic [15:0] rxw);
    logic [15:0] v, mask, got;
    int w;
    w    = wide ? 16 : 8;
    mask = wide ? 16'hFFFF : 16'h00FF;
    wr(2'd0, 16'h0001 | (16'(lsb) << 2) | (16'(wide) << 3));
    wr(2'd2, txw);
    ss_i = 1'b0;
    repeat (8) @(negedge clk);
    check("R13 miso_oe while selected", 32'(miso_oe), 32'd1);
    got = '0;
    for (int k = 0; k < w; k++) begin
      mosi_i = lsb ? rxw[k] : rxw[w-1-k];
      repeat (8) @(negedge clk);
      got[lsb ? k : w-1-k] = miso_o;
      sck_i = 1'b1;
      repeat (8) @(negedge clk);
      sck_i = 1'b0;
    end
    repeat (8) @(negedge clk);
    ss_i = 1'b1;
    repeat (4) @(negedge clk);
    check("R13 slave miso word", 32'(got), 32'(txw & mask));
    rd(2'd2, v);
    check("R13 slave received word", 32'(v), 32'(rxw & mask));
  endtask

  initial begin
    logic [15:0] v, tx, pat;
    rst_n = 1'b0; reg_addr = '0; reg_wr = 0; reg_rd = 0; reg_wdata = '0;
    sck_i = 0; mosi_i = 0; miso_i = 0; ss_i = 1'b1;
    cur_pat = '0; cur_lsb = 0; cur_w = 8;
    t_ssfall = 0; t_ssrise = 0; t_first = 0; t_lastfall = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check("R1 control reset", 32'(v), 32'h0);
    rd(2'd1, v); check("R1 status reset", 32'(v), 32'h2);
    check("R1 enables reset", {28'h0, sck_oe, mosi_oe, ss_oe, irq_match}, 32'h0);

    // R2 R3 R4 R6 R9 sweep of width, order and data
    for (int wd = 0; wd < 2; wd++)
      for (int ls = 0; ls < 2; ls++)
        for (int n = 0; n < 3; n++) begin
          tx  = 16'hA53C ^ 16'(n * 16'h1357) ^ 16'(wd * 16'h0F0F);
          pat = {tx[6:0], tx[15:7]} ^ 16'h5A69;
          master_frame(wd[0], ls[0], tx, pat, (n == 1) ? ~pat : pat);
          clr_flags();
        end

    // R9 compare limited to the active width
    master_frame(1'b0, 1'b0, 16'h00C3, 16'hFF96, 16'h1296);
    // R10 interrupt gating
    check("R10 irq off while disabled", 32'(irq_match), 32'd0);
    wr(2'd0, 16'h0073);
    check("R10 irq with enable", 32'(irq_match), 32'd1);
    // R11 clear sequence
    wr(2'd1, 16'h0000);
    wr(2'd1, 16'h0004);
    rd(2'd1, v);
    check("R11 unarmed write leaves match", 32'(v[2]), 32'd1);
    wr(2'd1, 16'h0004);
    rd(2'd1, v);
    check("R11 armed write clears match", 32'(v[2]), 32'd0);
    check("R10 irq drops with flag", 32'(irq_match), 32'd0);
    clr_flags();

    // R7 select decode
    wr(2'd0, 16'h0023);
    check("R7 select released without fault enable", 32'(ss_oe), 32'd0);
    ss_i = 1'b0;
    repeat (6) @(negedge clk);
    rd(2'd1, v);
    check("R7 low select ignored in master", 32'(v[3]), 32'd0);
    rd(2'd0, v);
    check("R7 master kept", 32'(v[1]), 32'd1);
    ss_i = 1'b1;
    wr(2'd0, 16'h0033);
    check("R6 select output enabled", 32'(ss_oe), 32'd1);
    wr(2'd0, 16'h0031);
    check("R7 slave never drives select", 32'(ss_oe), 32'd0);

    // R8 mode fault
    wr(2'd0, 16'h0013);
    check("R8 clock driven before fault", 32'(sck_oe), 32'd1);
    ss_i = 1'b0;
    repeat (6) @(negedge clk);
    rd(2'd1, v);
    check("R8 fault flag", 32'(v[3]), 32'd1);
    rd(2'd0, v);
    check("R8 demoted to slave", 32'(v), 32'h11);
    check("R8 outputs released", {30'h0, sck_oe, mosi_oe}, 32'h0);
    ss_i = 1'b1;
    repeat (4) @(negedge clk);
    rd(2'd1, v);
    wr(2'd1, 16'h0008);
    rd(2'd1, v);
    check("R11 fault flag cleared", 32'(v[3]), 32'd0);

    // R12 abort by width change
    wr(2'd0, 16'h003B);
    cur_w = 16; kidx = 0; ncap = 0;
    wr(2'd2, 16'h1234);
    repeat (3) @(posedge sck_o);
    wr(2'd0, 16'h0033);
    check("R12 select high after abort", 32'(ss_o), 32'd1);
    rd(2'd1, v);
    check("R12 status back to reset value", 32'(v), 32'h2);
    begin
      int n0;
      n0 = ncap;
      repeat (200) @(negedge clk);
      check("R12 no further clock edges", 32'(ncap), 32'(n0));
    end

    // R13 slave transfers
    slave_frame(1'b0, 1'b0, 16'h00A5, 16'h003C);
    slave_frame(1'b1, 1'b1, 16'hC0DE, 16'h8E71);
    slave_frame(1'b1, 1'b0, 16'h4B2D, 16'hF00F);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule